// File: doc/BRIEF.md
# Sleep Mode Clock-Domain Controller

This block decides which clock domains keep running when the processor executes its sleep instruction. Software first sets a sleep-enable bit and a 3-bit mode code. When the sleep request arrives and the enable is set, the controller captures the mode. It then drives five registered enables: the processor clock, the I/O peripheral clock, the converter clock, the asynchronous timer clock and the main oscillator. Each enable follows the domain set that the captured mode keeps alive.

Each mode allows its own subset of the five wake sources: external interrupt, reset request, asynchronous timer interrupt, other I/O interrupts and converter completion. A permitted source wakes the controller. If the mode stopped the main oscillator, the oscillator is switched on first. The remaining domains are held off for a parameterised start-up count. When every domain is running again, a one-cycle wake indication is raised.

Top module: `slp_clkctl`

## Requirements
- R1: After synchronous reset, or whenever reset is applied, all five enables are 1 and `wake_pulse` is 0. Reset also returns a sleeping controller to running.
- R2: A `sleep_req` sampled while `sleep_en` is 0 has no effect, and all enables stay 1.
- R3: Mode codes 3'b100 and 3'b101 are reserved and behave exactly like Idle (3'b000).
- R4: ADC quiet mode (3'b001) keeps only the converter clock, the asynchronous timer clock and the oscillator on. It wakes on external, reset, asynchronous timer or converter-done sources, and an I/O interrupt does not wake it.
- R5: Deep-off mode (3'b010) turns every enable off, including the oscillator. Only the external or reset sources wake it.
- R6: Timer-keep mode (3'b011) keeps only the asynchronous timer clock on. It wakes on external, reset or asynchronous timer sources.
- R7: Warm-idle mode (3'b110) keeps only the oscillator on. Only the external or reset sources wake it.
- R8: Warm-timer mode (3'b111) keeps the oscillator and the asynchronous timer clock on. It wakes on external, reset or asynchronous timer sources.
- R9: Idle (3'b000) turns off only the processor clock. Any of the five sources wakes it.
- R10: Sleep is entered on the clock edge that samples the request. In a mode that kept the oscillator on, the edge that samples a permitted source sets all enables to 1. `wake_pulse` is 1 for exactly that one cycle.
- R11: In a mode that stopped the oscillator, the wake edge turns `osc_en` on and leaves the other enables as they were during sleep. `STARTUP_CYC` cycles later, all enables become 1 together with a one-cycle `wake_pulse`. The processor clock is never on while the oscillator is off.
- R12: The mode is captured at entry. Changes of `mode_sel` and further `sleep_req` pulses while asleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Sleep permitted when 1 |
| mode_sel | input | 3 | Sleep mode code |
| sleep_req | input | 1 | Sleep instruction executed |
| wake_ext | input | 1 | External interrupt wake source |
| wake_rst | input | 1 | Reset request wake source |
| wake_atmr | input | 1 | Asynchronous timer interrupt |
| wake_io | input | 1 | Other I/O or timer interrupt |
| wake_adc | input | 1 | Converter completion interrupt |
| cpu_clk_en | output | 1 | Processor clock enable |
| io_clk_en | output | 1 | I/O peripheral clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| atmr_clk_en | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
The assertions check several properties on every cycle. The wake indication lasts one cycle and only appears with all domains running. The processor clock is never enabled without the oscillator. Deep-off sleep keeps everything dark. The enables stay frozen while asleep with no permitted source. The start-up counter stays in range. Only the bench scenarios can show the per-mode domain sets and the per-mode wake permissions. The same applies to the reserved-code aliasing, the exact length of the start-up wait, and the immunity to mode changes during sleep.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_IDLE  = 3'b000;
  localparam logic [MODE_W-1:0] MODE_ADCQ  = 3'b001;
  localparam logic [MODE_W-1:0] MODE_DOFF  = 3'b010;
  localparam logic [MODE_W-1:0] MODE_TKEEP = 3'b011;
  localparam logic [MODE_W-1:0] MODE_WIDLE = 3'b110;
  localparam logic [MODE_W-1:0] MODE_WTMR  = 3'b111;

  localparam int N_SRC    = 5;
  localparam int SRC_EXT  = 0;
  localparam int SRC_RST  = 1;
  localparam int SRC_ATMR = 2;
  localparam int SRC_IO   = 3;
  localparam int SRC_ADC  = 4;

  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic atmr;
    logic osc;
  } dom_t;

  localparam dom_t DOM_ALL = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, atmr: 1'b1, osc: 1'b1};

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WARM} st_e;
endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
  import slp_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output dom_t              keep,
  output logic [N_SRC-1:0]  allow
);
  localparam logic [N_SRC-1:0] ALLOW_ALL  = '1;
  localparam logic [N_SRC-1:0] ALLOW_HARD = (N_SRC'(1) << SRC_EXT) | (N_SRC'(1) << SRC_RST);
  localparam logic [N_SRC-1:0] ALLOW_TMR  = ALLOW_HARD | (N_SRC'(1) << SRC_ATMR);
  localparam logic [N_SRC-1:0] ALLOW_ADCQ = ALLOW_TMR | (N_SRC'(1) << SRC_ADC);

  always_comb begin
    keep  = DOM_ALL;
    allow = ALLOW_ALL;
    case (mode)
      MODE_ADCQ: begin
        keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b1, atmr: 1'b1, osc: 1'b1};
        allow = ALLOW_ADCQ;
      end
      MODE_DOFF: begin
        keep  = '0;
        allow = ALLOW_HARD;
      end
      MODE_TKEEP: begin
        keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, atmr: 1'b1, osc: 1'b0};
        allow = ALLOW_TMR;
      end
      MODE_WIDLE: begin
        keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, atmr: 1'b0, osc: 1'b1};
        allow = ALLOW_HARD;
      end
      MODE_WTMR: begin
        keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, atmr: 1'b1, osc: 1'b1};
        allow = ALLOW_TMR;
      end
      default: begin
        keep     = DOM_ALL;
        keep.cpu = 1'b0;
        allow    = ALLOW_ALL;
      end
    endcase
  end
endmodule

// File: rtl/slp_wake_gate.sv
module slp_wake_gate #(
  parameter int NS = 5
) (
  input  logic [NS-1:0] src,
  input  logic [NS-1:0] allow,
  output logic          hit
);
  logic [NS-1:0] qual;

  for (genvar i = 0; i < NS; i++) begin : g_src
    assign qual[i] = src[i] & allow[i];
  end

  assign hit = |qual;
endmodule

// File: rtl/slp_startup_cnt.sv
module slp_startup_cnt #(
  parameter int STARTUP_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(STARTUP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_V;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  a_r11_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD_V);
endmodule

// File: rtl/slp_clkctl.sv
module slp_clkctl
  import slp_pkg::*;
#(
  parameter int STARTUP_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_en,
  input  logic [2:0] mode_sel,
  input  logic       sleep_req,
  input  logic       wake_ext,
  input  logic       wake_rst,
  input  logic       wake_atmr,
  input  logic       wake_io,
  input  logic       wake_adc,
  output logic       cpu_clk_en,
  output logic       io_clk_en,
  output logic       adc_clk_en,
  output logic       atmr_clk_en,
  output logic       osc_en,
  output logic       wake_pulse
);
  st_e              st_q, st_d;
  dom_t             dom_q, dom_d;
  logic [MODE_W-1:0] mode_q, mode_d, dec_mode;
  logic             pulse_q, pulse_d;
  dom_t             keep;
  logic [N_SRC-1:0] allow, src_vec;
  logic             wake_hit, cnt_load, cnt_done;

  assign src_vec  = {wake_adc, wake_io, wake_atmr, wake_rst, wake_ext};
  assign dec_mode = (st_q == ST_RUN) ? mode_sel : mode_q;

  slp_mode_decode i_dec (
    .mode  (dec_mode),
    .keep  (keep),
    .allow (allow)
  );

  slp_wake_gate #(.NS(N_SRC)) i_gate (
    .src   (src_vec),
    .allow (allow),
    .hit   (wake_hit)
  );

  slp_startup_cnt #(.STARTUP_CYC(STARTUP_CYC)) i_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (cnt_load),
    .run  (st_q == ST_WARM),
    .done (cnt_done)
  );

  always_comb begin
    st_d     = st_q;
    dom_d    = dom_q;
    mode_d   = mode_q;
    pulse_d  = 1'b0;
    cnt_load = 1'b0;
    case (st_q)
      ST_RUN: begin
        dom_d = DOM_ALL;
        if (sleep_req && sleep_en) begin
          st_d   = ST_SLEEP;
          mode_d = mode_sel;
          dom_d  = keep;
        end
      end
      ST_SLEEP: begin
        if (wake_hit) begin
          if (keep.osc) begin
            st_d    = ST_RUN;
            dom_d   = DOM_ALL;
            pulse_d = 1'b1;
          end else begin
            st_d      = ST_WARM;
            dom_d.osc = 1'b1;
            cnt_load  = 1'b1;
          end
        end
      end
      ST_WARM: begin
        if (cnt_done) begin
          st_d    = ST_RUN;
          dom_d   = DOM_ALL;
          pulse_d = 1'b1;
        end
      end
      default: begin
        st_d  = ST_RUN;
        dom_d = DOM_ALL;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RUN;
      dom_q   <= DOM_ALL;
      mode_q  <= MODE_IDLE;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      dom_q   <= dom_d;
      mode_q  <= mode_d;
      pulse_q <= pulse_d;
    end
  end

  assign cpu_clk_en  = dom_q.cpu;
  assign io_clk_en   = dom_q.io;
  assign adc_clk_en  = dom_q.adc;
  assign atmr_clk_en = dom_q.atmr;
  assign osc_en      = dom_q.osc;
  assign wake_pulse  = pulse_q;

  a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  a_r10_pulse_all_on: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (cpu_clk_en && io_clk_en && adc_clk_en && atmr_clk_en && osc_en));

  a_r11_osc_before_cpu: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !cpu_clk_en);

  a_r2_no_entry: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !sleep_en) |=> cpu_clk_en);

  a_r5_doff_dark: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP && mode_q == MODE_DOFF) |->
      !(cpu_clk_en || io_clk_en || adc_clk_en || atmr_clk_en || osc_en));

  a_r12_frozen: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP && !wake_hit) |=>
      $stable({cpu_clk_en, io_clk_en, adc_clk_en, atmr_clk_en, osc_en}));
endmodule

// File: tb/test_slp_clkctl.sv
module test_slp_clkctl;
  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 5;
  localparam int NV         = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_en = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       sleep_req = 1'b0;
  logic [4:0] wv = '0;
  logic       cpu_clk_en, io_clk_en, adc_clk_en, atmr_clk_en, osc_en, wake_pulse;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slp_clkctl #(.STARTUP_CYC(STARTUP)) i_slp_clkctl (
    .clk         (clk),
    .rst         (rst),
    .sleep_en    (sleep_en),
    .mode_sel    (mode_sel),
    .sleep_req   (sleep_req),
    .wake_ext    (wv[0]),
    .wake_rst    (wv[1]),
    .wake_atmr   (wv[2]),
    .wake_io     (wv[3]),
    .wake_adc    (wv[4]),
    .cpu_clk_en  (cpu_clk_en),
    .io_clk_en   (io_clk_en),
    .adc_clk_en  (adc_clk_en),
    .atmr_clk_en (atmr_clk_en),
    .osc_en      (osc_en),
    .wake_pulse  (wake_pulse)
  );

  // entry: {mode[2:0], source index[2:0], wakes, kept set {cpu,io,adc,atmr,osc}}
  localparam logic [11:0] TBL [NV] = '{
    {3'b000, 3'd3, 1'b1, 5'b01111},
    {3'b000, 3'd4, 1'b1, 5'b01111},
    {3'b100, 3'd2, 1'b1, 5'b01111},
    {3'b101, 3'd0, 1'b1, 5'b01111},
    {3'b001, 3'd3, 1'b0, 5'b00111},
    {3'b001, 3'd4, 1'b1, 5'b00111},
    {3'b001, 3'd2, 1'b1, 5'b00111},
    {3'b010, 3'd2, 1'b0, 5'b00000},
    {3'b010, 3'd0, 1'b1, 5'b00000},
    {3'b010, 3'd1, 1'b1, 5'b00000},
    {3'b011, 3'd3, 1'b0, 5'b00010},
    {3'b011, 3'd2, 1'b1, 5'b00010},
    {3'b110, 3'd4, 1'b0, 5'b00001},
    {3'b110, 3'd1, 1'b1, 5'b00001},
    {3'b111, 3'd2, 1'b1, 5'b00011},
    {3'b111, 3'd3, 1'b0, 5'b00011}
  };

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'b000:  return "R9";
      3'b001:  return "R4";
      3'b010:  return "R5";
      3'b011:  return "R6";
      3'b110:  return "R7";
      3'b111:  return "R8";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [5:0] outs();
    return {cpu_clk_en, io_clk_en, adc_clk_en, atmr_clk_en, osc_en, wake_pulse};
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter(input logic [2:0] m);
    sleep_en  = 1'b1;
    mode_sel  = m;
    sleep_req = 1'b1;
    adv();
    sleep_req = 1'b0;
  endtask

  // called one sample after the edge that saw a permitted source
  task automatic wake_seq(input logic [4:0] kept);
    if (kept[0]) begin
      chk("R10 wake", outs(), 6'b111111);
      adv();
      chk("R10 pulse end", outs(), 6'b111110);
    end else begin
      chk("R11 osc first", outs(), {kept | 5'b00001, 1'b0});
      for (int i = 1; i < STARTUP; i++) begin
        adv();
        chk("R11 hold", outs(), {kept | 5'b00001, 1'b0});
      end
      adv();
      chk("R11 release", outs(), 6'b111111);
      adv();
      chk("R11 pulse end", outs(), 6'b111110);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog: got running expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    adv();
    adv();
    rst = 1'b0;
    chk("R1 reset state", outs(), 6'b111110);

    // R2: request without enable
    sleep_en  = 1'b0;
    mode_sel  = 3'b010;
    sleep_req = 1'b1;
    adv();
    sleep_req = 1'b0;
    chk("R2 ignored", outs(), 6'b111110);
    adv();
    chk("R2 still running", outs(), 6'b111110);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] m;
      logic [2:0] s;
      logic       wk;
      logic [4:0] kept;
      {m, s, wk, kept} = TBL[v];
      enter(m);
      chk(req_of(m), outs(), {kept, 1'b0});
      wv[s] = 1'b1;
      adv();
      wv = '0;
      if (wk) begin
        wake_seq(kept);
      end else begin
        chk(req_of(m), outs(), {kept, 1'b0});
        wv[0] = 1'b1;
        adv();
        wv = '0;
        wake_seq(kept);
      end
    end

    // R12: mode change and new request while asleep have no effect
    enter(3'b010);
    mode_sel  = 3'b000;
    sleep_req = 1'b1;
    wv[3]     = 1'b1;
    adv();
    wv        = '0;
    sleep_req = 1'b0;
    chk("R12 mode held", outs(), 6'b000000);
    wv[1] = 1'b1;
    adv();
    wv = '0;
    wake_seq(5'b00000);

    // R1: reset while in timer-keep sleep
    enter(3'b011);
    chk("R6 entry", outs(), 6'b000100);
    rst = 1'b1;
    adv();
    rst = 1'b0;
    chk("R1 reset in sleep", outs(), 6'b111110);

    // R1: reset in the middle of the start-up wait
    enter(3'b010);
    wv[0] = 1'b1;
    adv();
    wv = '0;
    chk("R11 warm", outs(), 6'b000010);
    rst = 1'b1;
    adv();
    rst = 1'b0;
    chk("R1 reset in warm", outs(), 6'b111110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule